// File: doc/BRIEF.md
# Eight-bit Timer/Counter with Clear-on-Compare

This block is an up-counting timer with a width set by a parameter (eight bits by default). It advances by one on every cycle where a tick-enable input is high. That input stands for the output of a prescaler that lives outside the block. Software can load the count at any time. Software can also rewrite a compare register, and the new value takes effect at once with no shadow copy. A two-bit waveform mode selects how the count runs. In free-running mode the count wraps from all-ones back to zero. In clear-on-compare mode the count returns to zero after it has reached the compare value, so the compare value sets the period.

Two sticky event flags record what the counter has done. The overflow flag sets when the count passes all-ones to zero, and it acts as a set-only ninth count bit. The compare flag sets when the count equals the compare value. Each flag drives an interrupt request gated by its own enable. Each flag clears through either a software clear strobe or an interrupt acknowledge. A two-bit pin-action field picks what a compare match does to a waveform output pin: nothing, toggle, drive low or drive high. The pin-action field never changes the count sequence.

Top module: `tmr8_cc`

## Requirements
- R1: After reset, `count`, `compare`, both flags, both interrupt requests and `wave_out` are all zero.
- R2: The count changes only at a clock edge where `tick_en` is high or `cnt_we` is high. With both low, the count holds.
- R3: With `wave_mode` = 0, each tick adds one to the count. The count wraps from 0xFF to 0x00 and is never cleared by a compare match.
- R4: With `wave_mode` = 2, a tick taken while `count` equals `compare` loads zero instead of count+1. The period is therefore `compare`+1 ticks.
- R5: `ovf_flag` sets at the same edge where a tick moves the count from all-ones to zero, in every mode. It stays set until it is cleared.
- R6: `cmp_flag` sets at the edge of every tick taken while `count` equals `compare`, in every mode. It stays set until it is cleared.
- R7: A high `ovf_clr` or `ovf_ack` clears `ovf_flag` at the next edge, and `cmp_clr` or `cmp_ack` does the same for `cmp_flag`. If the flag's set event falls in the same cycle, the set wins.
- R8: `ovf_irq` equals `ovf_flag` AND `ovf_ie`, and `cmp_irq` equals `cmp_flag` AND `cmp_ie`.
- R9: At the edge of a compare-match tick, `wave_out` follows `out_mode`: 0 leaves it unchanged, 1 inverts it, 2 drives it to 0, 3 drives it to 1. `out_mode` has no effect on the count.
- R10: A `cmp_we` write loads `compare` at the next edge with no buffering. The match in that same cycle uses the old value. If the new value is below the count in `wave_mode` = 2, the count runs on to 0xFF, wraps to 0x00 and sets `ovf_flag`.
- R11: A `cnt_we` write loads `count` at the next edge. If a tick falls in the same cycle, the write wins, and that tick's increment, flag sets and pin action are all discarded.
- R12: `wave_mode` values 1 and 3 behave exactly as value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count tick from the external prescaler |
| wave_mode | input | 2 | 0,1,3 free-running; 2 clear-on-compare |
| out_mode | input | 2 | Pin action on match: 0 none, 1 toggle, 2 low, 3 high |
| cnt_we | input | 1 | Software write strobe for the count |
| cnt_wdata | input | CNT_W | Count write value |
| cmp_we | input | 1 | Software write strobe for the compare register |
| cmp_wdata | input | CNT_W | Compare write value |
| ovf_clr | input | 1 | Software clear of the overflow flag |
| cmp_clr | input | 1 | Software clear of the compare flag |
| ovf_ack | input | 1 | Overflow interrupt acknowledge |
| cmp_ack | input | 1 | Compare interrupt acknowledge |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cmp_ie | input | 1 | Compare interrupt enable |
| count | output | CNT_W | Current count |
| compare | output | CNT_W | Current compare value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |
| wave_out | output | 1 | Waveform output pin |

## Verification
The following results all land at the first clock edge after the stimulus, with no added pipeline stage: the count, the compare value, both flags and the pin. The interrupt requests follow the flags and enables with no delay at all. The bench drives every stimulus two nanoseconds after an edge and advances a reference model computed from the requirements. It then compares every output two nanoseconds after the next edge, so each result is checked in the cycle it is due. The sweeps cover every mode value, every pin action and a set of compare values including 0 and 0xFF over whole periods. They also cover tick gaps, collisions between a write and a tick, collisions between a clear and a set, and a compare lowered beneath the running count.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int TMR_W = 8;

    typedef enum logic [1:0] {
        WM_FREE    = 2'd0,
        WM_PWM_A   = 2'd1,
        WM_CLR_CMP = 2'd2,
        WM_PWM_B   = 2'd3
    } wave_mode_e;

    typedef enum logic [1:0] {
        PA_NONE   = 2'd0,
        PA_TOGGLE = 2'd1,
        PA_LOW    = 2'd2,
        PA_HIGH   = 2'd3
    } pin_act_e;

    localparam int FLG_OVF = 0;
    localparam int FLG_CMP = 1;
    localparam int FLG_N   = 2;

endpackage

// File: rtl/tmr8_count.sv
module tmr8_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         clr_on_match,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] compare,
    output logic         ovf_evt,
    output logic         match_evt
);
    localparam logic [W-1:0] CNT_MAX  = {W{1'b1}};
    localparam logic [W-1:0] CNT_ZERO = '0;
    localparam logic [W-1:0] CNT_ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cmp;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    tick_ok;
    logic    at_top;
    logic    at_max;

    always_comb begin
        tick_ok   = tick_en & ~cnt_we;
        at_top    = (st_q.cnt == st_q.cmp);
        at_max    = (st_q.cnt == CNT_MAX);
        match_evt = tick_ok & at_top;
        ovf_evt   = tick_ok & at_max;

        st_d = st_q;
        if (cnt_we) begin
            st_d.cnt = cnt_wdata;
        end else if (tick_en) begin
            if (clr_on_match && at_top) begin
                st_d.cnt = CNT_ZERO;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
        if (cmp_we) begin
            st_d.cmp = cmp_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign compare = st_q.cmp;

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] ack,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flag,
    output logic [N-1:0] irq
);
    logic [N-1:0] flag_d, flag_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            flag_d[i] = set_evt[i] | (flag_q[i] & ~(sw_clr[i] | ack[i]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_irq
        assign irq[g] = flag_q[g] & ie[g];
    end

    assign flag = flag_q;

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
    import tmr8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match_evt,
    input  logic [1:0] out_mode,
    output logic       wave_out
);
    logic pin_d, pin_q;

    always_comb begin
        pin_d = pin_q;
        if (match_evt) begin
            case (pin_act_e'(out_mode))
                PA_TOGGLE: pin_d = ~pin_q;
                PA_LOW:    pin_d = 1'b0;
                PA_HIGH:   pin_d = 1'b1;
                default:   pin_d = pin_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign wave_out = pin_q;

endmodule

// File: rtl/tmr8_cc.sv
module tmr8_cc
    import tmr8_pkg::*;
#(
    parameter int CNT_W = TMR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [1:0]       wave_mode,
    input  logic [1:0]       out_mode,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             ovf_clr,
    input  logic             cmp_clr,
    input  logic             ovf_ack,
    input  logic             cmp_ack,
    input  logic             ovf_ie,
    input  logic             cmp_ie,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] compare,
    output logic             ovf_flag,
    output logic             cmp_flag,
    output logic             ovf_irq,
    output logic             cmp_irq,
    output logic             wave_out
);
    logic             clr_on_match;
    logic             ovf_evt;
    logic             match_evt;
    logic [FLG_N-1:0] f_set, f_clr, f_ack, f_ie, f_flag, f_irq;

    // Only the clear-on-compare encoding alters the sequence; PWM codes fall back to free-running.
    assign clr_on_match = (wave_mode_e'(wave_mode) == WM_CLR_CMP);

    tmr8_count #(.W(CNT_W)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .clr_on_match (clr_on_match),
        .cnt_we       (cnt_we),
        .cnt_wdata    (cnt_wdata),
        .cmp_we       (cmp_we),
        .cmp_wdata    (cmp_wdata),
        .count        (count),
        .compare      (compare),
        .ovf_evt      (ovf_evt),
        .match_evt    (match_evt)
    );

    always_comb begin
        f_set[FLG_OVF] = ovf_evt;
        f_set[FLG_CMP] = match_evt;
        f_clr[FLG_OVF] = ovf_clr;
        f_clr[FLG_CMP] = cmp_clr;
        f_ack[FLG_OVF] = ovf_ack;
        f_ack[FLG_CMP] = cmp_ack;
        f_ie[FLG_OVF]  = ovf_ie;
        f_ie[FLG_CMP]  = cmp_ie;
    end

    tmr8_flags #(.N(FLG_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (f_set),
        .sw_clr  (f_clr),
        .ack     (f_ack),
        .ie      (f_ie),
        .flag    (f_flag),
        .irq     (f_irq)
    );

    assign ovf_flag = f_flag[FLG_OVF];
    assign cmp_flag = f_flag[FLG_CMP];
    assign ovf_irq  = f_irq[FLG_OVF];
    assign cmp_irq  = f_irq[FLG_CMP];

    tmr8_wave u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_evt (match_evt),
        .out_mode  (out_mode),
        .wave_out  (wave_out)
    );

endmodule

// File: rtl/tmr8_cc_chk.sv
module tmr8_cc_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_en,
    input logic [1:0]   wave_mode,
    input logic [1:0]   out_mode,
    input logic         cnt_we,
    input logic [W-1:0] cnt_wdata,
    input logic         ovf_clr,
    input logic         ovf_ack,
    input logic [W-1:0] count,
    input logic [W-1:0] compare,
    input logic         ovf_flag,
    input logic         cmp_flag,
    input logic         wave_out
);
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cnt_we) |=> $stable(count));

    a_r3_free_run_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_we && wave_mode != 2'd2) |=> (count == $past(count) + ONE));

    a_r4_clear_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_we && wave_mode == 2'd2 && count == compare) |=> (count == '0));

    a_r5_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_we && count == ONES) |=> ovf_flag);

    a_r6_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_we && count == compare) |=> cmp_flag);

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr && !ovf_ack) |=> ovf_flag);

    a_r9_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_we && count == compare && out_mode == 2'd1) |=> (wave_out != $past(wave_out)));

    a_r9_no_action_keeps_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'd0) |=> $stable(wave_out));

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (count == $past(cnt_wdata)));

endmodule

bind tmr8_cc tmr8_cc_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wave_mode (wave_mode),
    .out_mode  (out_mode),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .ovf_clr   (ovf_clr),
    .ovf_ack   (ovf_ack),
    .count     (count),
    .compare   (compare),
    .ovf_flag  (ovf_flag),
    .cmp_flag  (cmp_flag),
    .wave_out  (wave_out)
);

// File: tb/tmr8_cc_tb.sv
module tmr8_cc_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n;
    logic         tick_en;
    logic [1:0]   wave_mode, out_mode;
    logic         cnt_we, cmp_we;
    logic [W-1:0] cnt_wdata, cmp_wdata;
    logic         ovf_clr, cmp_clr, ovf_ack, cmp_ack, ovf_ie, cmp_ie;
    logic [W-1:0] count, compare;
    logic         ovf_flag, cmp_flag, ovf_irq, cmp_irq, wave_out;

    tmr8_cc #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wave_mode(wave_mode),
        .out_mode(out_mode), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .ovf_clr(ovf_clr),
        .cmp_clr(cmp_clr), .ovf_ack(ovf_ack), .cmp_ack(cmp_ack),
        .ovf_ie(ovf_ie), .cmp_ie(cmp_ie), .count(count), .compare(compare),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .ovf_irq(ovf_irq),
        .cmp_irq(cmp_irq), .wave_out(wave_out)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    logic [W-1:0] m_cnt, m_cmp;
    logic         m_ovf, m_cf, m_pin;
    logic [15:0]  lfsr = 16'hACE1;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("count",    32'(count),    32'(m_cnt));
        chk("compare",  32'(compare),  32'(m_cmp));
        chk("ovf_flag", 32'(ovf_flag), 32'(m_ovf));
        chk("cmp_flag", 32'(cmp_flag), 32'(m_cf));
        chk("ovf_irq R8", 32'(ovf_irq), 32'(m_ovf & ovf_ie));
        chk("cmp_irq R8", 32'(cmp_irq), 32'(m_cf & cmp_ie));
        chk("wave_out", 32'(wave_out), 32'(m_pin));
    endtask

    // One clock: advance the requirement model from the inputs now applied, then compare after the edge.
    task automatic cyc();
        logic         ev_o, ev_m;
        logic [W-1:0] nxt;
        ev_o = 1'b0;
        ev_m = 1'b0;
        nxt  = m_cnt;
        if (cnt_we) begin
            nxt = cnt_wdata;
        end else if (tick_en) begin
            ev_o = (m_cnt == 8'hFF);
            ev_m = (m_cnt == m_cmp);
            nxt  = (wave_mode == 2'd2 && ev_m) ? 8'h00 : m_cnt + 8'h01;
        end
        m_ovf = ev_o | (m_ovf & ~(ovf_clr | ovf_ack));
        m_cf  = ev_m | (m_cf & ~(cmp_clr | cmp_ack));
        if (ev_m) begin
            case (out_mode)
                2'd1: m_pin = ~m_pin;
                2'd2: m_pin = 1'b0;
                2'd3: m_pin = 1'b1;
                default: ;
            endcase
        end
        m_cnt = nxt;
        if (cmp_we) m_cmp = cmp_wdata;
        @(posedge clk);
        #2;
        cnt_we = 1'b0; cmp_we = 1'b0;
        ovf_clr = 1'b0; cmp_clr = 1'b0; ovf_ack = 1'b0; cmp_ack = 1'b0;
        check_all();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            if (i % 37 == 36) begin ovf_ack = 1'b1; cmp_clr = 1'b1; end
            if (i % 23 == 22) begin ovf_clr = 1'b1; cmp_ack = 1'b1; end
            cyc();
        end
    endtask

    task automatic load(input logic [W-1:0] c, input logic [W-1:0] k);
        cnt_we = 1'b1; cnt_wdata = c;
        cmp_we = 1'b1; cmp_wdata = k;
        tick_en = 1'b0;
        cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; wave_mode = 2'd0; out_mode = 2'd0;
        cnt_we = 1'b0; cmp_we = 1'b0; cnt_wdata = '0; cmp_wdata = '0;
        ovf_clr = 1'b0; cmp_clr = 1'b0; ovf_ack = 1'b0; cmp_ack = 1'b0;
        ovf_ie = 1'b1; cmp_ie = 1'b1;
        m_cnt = '0; m_cmp = '0; m_ovf = 1'b0; m_cf = 1'b0; m_pin = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        cur_req = "R1";
        check_all();
        rst_n = 1'b1;

        // R2: no tick, no write -> nothing moves
        cur_req = "R2";
        tick_en = 1'b1; cyc(); cyc();
        tick_en = 1'b0;
        for (int i = 0; i < 6; i++) cyc();

        // R3 / R5 / R6 / R9: free-running over a full wrap with a toggling pin
        cur_req = "R3";
        wave_mode = 2'd0; out_mode = 2'd1;
        load(8'h00, 8'h40);
        ticks(300);
        cur_req = "R5";
        load(8'hFD, 8'h40);
        ticks(4);
        chk("R5 overflow flag held", 32'(ovf_flag), 32'd1);

        // R12: PWM codes behave as free-running
        for (int md = 1; md < 4; md += 2) begin
            cur_req = "R12";
            wave_mode = 2'(md);
            load(8'hF0, 8'hF8);
            ticks(280);
        end

        // R4 / R6 / R9: clear-on-compare sweep over compare values and pin actions
        wave_mode = 2'd2;
        for (int pa = 0; pa < 4; pa++) begin
            for (int ci = 0; ci < 6; ci++) begin
                logic [W-1:0] top;
                case (ci)
                    0: top = 8'h00;
                    1: top = 8'h01;
                    2: top = 8'h02;
                    3: top = 8'h07;
                    4: top = 8'h80;
                    default: top = 8'hFF;
                endcase
                cur_req = (pa == 0) ? "R4" : "R9";
                out_mode = 2'(pa);
                load(8'h00, top);
                ticks(2 * (int'(top) + 1) + 3);
            end
        end

        // R10: compare lowered beneath the running count
        cur_req = "R10";
        out_mode = 2'd1;
        load(8'h00, 8'h60);
        ticks(16'h50);
        ovf_clr = 1'b1; tick_en = 1'b0; cyc();
        cmp_we = 1'b1; cmp_wdata = 8'h20; tick_en = 1'b1;
        cyc();
        for (int i = 0; i < 175; i++) begin tick_en = 1'b1; cyc(); end
        chk("R10 count wrapped past top", 32'(count), 32'h0);
        chk("R10 overflow after wrap", 32'(ovf_flag), 32'd1);
        ticks(60);

        // R11: write and tick in the same cycle
        cur_req = "R11";
        wave_mode = 2'd0;
        load(8'hFF, 8'hFF);
        ovf_clr = 1'b1; cmp_clr = 1'b1; tick_en = 1'b0; cyc();
        cnt_we = 1'b1; cnt_wdata = 8'h33; tick_en = 1'b1; cyc();
        chk("R11 write beats tick", 32'(count), 32'h33);
        chk("R11 no overflow from dropped tick", 32'(ovf_flag), 32'd0);
        chk("R11 no match from dropped tick", 32'(cmp_flag), 32'd0);

        // R7: clear and set in the same cycle -> set wins
        cur_req = "R7";
        load(8'hFF, 8'hFF);
        tick_en = 1'b1; ovf_clr = 1'b1; cmp_ack = 1'b1; cyc();
        chk("R7 set beats clear", 32'(ovf_flag), 32'd1);
        tick_en = 1'b0; ovf_ack = 1'b1; cmp_clr = 1'b1; cyc();
        chk("R7 ack clears", 32'(ovf_flag), 32'd0);

        // R8 plus mixed traffic: pseudo-random ticks, enables, clears, writes
        cur_req = "R8";
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick_en = lfsr[0] | lfsr[1];
            ovf_ie  = lfsr[2];
            cmp_ie  = lfsr[3];
            ovf_ack = (lfsr[7:4] == 4'h0);
            cmp_clr = (lfsr[7:4] == 4'h1);
            cnt_we  = (lfsr[11:8] == 4'hA) && lfsr[12];
            cnt_wdata = lfsr[15:8];
            cmp_we  = (lfsr[11:8] == 4'h5);
            cmp_wdata = {1'b0, lfsr[14:8]};
            if (i % 500 == 0) begin
                wave_mode = 2'(i / 500);
                out_mode  = 2'(i / 250);
            end
            cyc();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule